// File: doc/BRIEF.md
# Snapshot-on-read interrupt status unit

This unit collects the interrupt events of a network controller into one 32-bit live status word and drives a single interrupt line. Each datapath source raises its bit with a one-cycle pulse. An enable mask decides which pending bits may assert the line. Software reaches the unit through a plain register port that has a read strobe, a write strobe, an offset and a data word. Three offsets are decoded: live status at 0x000, enable at 0x004 and hold at 0x018.

Reading the live status is a clear-on-read. In one clock the read copies the live word into a read-only hold register, captures the current receive and transmit hardware descriptor pointers, and clears the live word. The read returns the value it just captured, so software gets a consistent view of the pending events and of how far both rings had advanced. Software can later fetch the same snapshot again from the hold offset with no side effect. An event that arrives in the same cycle as the clearing read is kept in the live word, so no event is lost.

Top module: `irq_snapshot_unit`

## Requirements
- R1: After reset the live status, the enable mask, the hold register, both pointer hold outputs and the read data are zero, and the interrupt line is low.
- R2: A pulse on bit n of the event input sets live status bit n, and the bit stays set until a clearing read. Only the defined bits 0-5, 8-12, 16, 20, 24 and 28 (mask 0x11111F3F) can be set. All other bits always read as zero.
- R3: The interrupt line is high exactly when the live status and the enable mask share a set bit. It is evaluated from registered state in the cycle after that state changes.
- R4: A write to offset 0x004 stores the write data ANDed with 0x11111F3F into the enable mask. A read of 0x004 returns the mask.
- R5: A read of offset 0x000 returns the live status as it stood before the read. In the same cycle the read copies that value into the hold register and clears the live status.
- R6: A read of offset 0x000 latches the receive and transmit pointer inputs into the two pointer hold outputs. The outputs change at no other time.
- R7: An event pulse in the same cycle as a read of 0x000 stays set in the live status after the read, and it is not part of that read's snapshot.
- R8: A read of offset 0x018 returns the hold register. It leaves the live status, the hold register and the pointer holds unchanged.
- R9: Writes to offsets 0x000 and 0x018 change no state.
- R10: Read data is registered. It is valid in the cycle after the read strobe and holds its value until the next read. A read of any offset other than 0x000, 0x004 or 0x018 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | One-cycle event pulses, one bit per interrupt source |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (9) | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rx_ptr_i | input | PTR_W (32) | Current receive hardware descriptor pointer |
| tx_ptr_i | input | PTR_W (32) | Current transmit hardware descriptor pointer |
| rx_ptr_hold_o | output | PTR_W (32) | Receive pointer captured by the last clearing read |
| tx_ptr_hold_o | output | PTR_W (32) | Transmit pointer captured by the last clearing read |
| irq_o | output | 1 | Interrupt line |

## Verification
The properties assume that the event input is sampled as level pulses on clock edges. They also assume that a clearing read is identified only by the read strobe together with offset 0x000, so a write in the same cycle to any offset must not disturb the snapshot. The stimulus drives every input half a cycle away from the active edge. It deliberately places event pulses on reserved bits, in the same cycle as clearing reads, and alongside simultaneous reads and writes. Pointer inputs change on every cycle so that a capture at the wrong moment is visible on the pointer hold outputs.

// File: rtl/irq_snapshot_unit.sv
module irq_snapshot_unit #(
  parameter int ADDR_W = 9,
  parameter int PTR_W  = 32,
  parameter logic [31:0] DEF_MASK = 32'h1111_1F3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       evt_i,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [PTR_W-1:0]  rx_ptr_i,
  input  logic [PTR_W-1:0]  tx_ptr_i,
  output logic [PTR_W-1:0]  rx_ptr_hold_o,
  output logic [PTR_W-1:0]  tx_ptr_hold_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_HOLD = ADDR_W'(12'h018);

  logic [31:0] status_q, en_q, hold_q;
  logic [31:0] evt_m;
  logic        clr_rd;

  assign evt_m  = evt_i & DEF_MASK;
  assign clr_rd = rd_en && (addr == OFF_STAT);
  assign irq_o  = |(status_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q      <= '0;
      en_q          <= '0;
      hold_q        <= '0;
      rx_ptr_hold_o <= '0;
      tx_ptr_hold_o <= '0;
      rdata         <= '0;
    end else begin
      status_q <= clr_rd ? evt_m : (status_q | evt_m);
      if (clr_rd) begin
        hold_q        <= status_q;
        rx_ptr_hold_o <= rx_ptr_i;
        tx_ptr_hold_o <= tx_ptr_i;
      end
      if (wr_en && addr == OFF_EN) en_q <= wdata & DEF_MASK;
      if (rd_en) begin
        case (addr)
          OFF_STAT: rdata <= status_q;
          OFF_EN:   rdata <= en_q;
          OFF_HOLD: rdata <= hold_q;
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

module irq_snapshot_unit_chk #(
  parameter int ADDR_W = 9,
  parameter int PTR_W  = 32,
  parameter logic [31:0] DEF_MASK = 32'h1111_1F3F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       evt_i,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [PTR_W-1:0]  rx_ptr_i,
  input logic [PTR_W-1:0]  tx_ptr_i,
  input logic [PTR_W-1:0]  rx_ptr_hold_o,
  input logic [PTR_W-1:0]  tx_ptr_hold_o,
  input logic              irq_o,
  input logic [31:0]       status_q,
  input logic [31:0]       en_q,
  input logic [31:0]       hold_q
);
  logic clr;
  assign clr = rd_en && (addr == '0);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~DEF_MASK) == '0);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((status_q & $past(status_q)) == $past(status_q)));
  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0 && status_q != '0));
  p_enable_defined_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~DEF_MASK) == '0);
  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hold_q == $past(status_q) && rdata == $past(status_q)));
  p_ptr_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rx_ptr_hold_o == $past(rx_ptr_i) && tx_ptr_hold_o == $past(tx_ptr_i)));
  p_event_survives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status_q == ($past(evt_i) & DEF_MASK)));
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($stable(hold_q) && $stable(rx_ptr_hold_o) && $stable(tx_ptr_hold_o)));
  p_rdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_snapshot_unit irq_snapshot_unit_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DEF_MASK(DEF_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rx_ptr_i(rx_ptr_i), .tx_ptr_i(tx_ptr_i),
  .rx_ptr_hold_o(rx_ptr_hold_o), .tx_ptr_hold_o(tx_ptr_hold_o), .irq_o(irq_o),
  .status_q(status_q), .en_q(en_q), .hold_q(hold_q)
);

// File: tb/irq_snapshot_unit_tb_top.sv
module irq_snapshot_unit_tb_top;
  localparam int ADDR_W = 9;
  localparam int PTR_W  = 32;
  localparam logic [31:0] MSK = 32'h1111_1F3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [PTR_W-1:0] rx_ptr_i = '0, tx_ptr_i = '0;
  logic [PTR_W-1:0] rx_ptr_hold_o, tx_ptr_hold_o;
  logic irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0, m_en = '0, m_hold = '0, m_rd = '0;
  logic [PTR_W-1:0] m_rx = '0, m_tx = '0;

  always #10 clk = ~clk;

  irq_snapshot_unit #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_ptr_i(rx_ptr_i),
    .tx_ptr_i(tx_ptr_i), .rx_ptr_hold_o(rx_ptr_hold_o),
    .tx_ptr_hold_o(tx_ptr_hold_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rdata", 64'(rdata), 64'(m_rd));
    chk("R3", "irq", 64'(irq_o), 64'(|(m_stat & m_en)));
    chk("R6", "rx_hold", 64'(rx_ptr_hold_o), 64'(m_rx));
    chk("R6", "tx_hold", 64'(tx_ptr_hold_o), 64'(m_tx));
  endtask

  // drive one cycle at negedge, advance the model, compare at next negedge
  task automatic cyc(string tag, logic [31:0] ev, logic rd, logic wr,
                     logic [ADDR_W-1:0] a, logic [31:0] wd,
                     logic [PTR_W-1:0] rxp, logic [PTR_W-1:0] txp);
    logic [31:0] ns;
    evt_i = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    rx_ptr_i = rxp; tx_ptr_i = txp;
    ns = m_stat | (ev & MSK);
    if (rd) begin
      if (a == 0) m_rd = m_stat;
      else if (a == 4) m_rd = m_en;
      else if (a == 'h18) m_rd = m_hold;
      else m_rd = 0;
    end
    if (rd && a == 0) begin
      m_hold = m_stat; m_rx = rxp; m_tx = txp; ns = ev & MSK;
    end
    if (wr && a == 4) m_en = wd & MSK;
    m_stat = ns;
    @(negedge clk);
    evt_i = '0; rd_en = 0; wr_en = 0;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    compare("R1");
    chk("R1", "irq_reset", 64'(irq_o), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R10", 0, 1, 0, 'h18, 0, 1, 2);           // hold reads zero after reset (R1)
    cyc("R4", 0, 0, 1, 4, 32'hFFFF_FFFF, 3, 4);
    cyc("R4", 0, 1, 0, 4, 0, 5, 6);
    chk("R4", "enable_readback", 64'(rdata), 64'(MSK));
    cyc("R2", 32'hFFFF_FFFF, 0, 0, 0, 0, 7, 8);    // reserved bits ignored
    cyc("R2", 0, 0, 0, 0, 0, 9, 10);               // still set
    cyc("R5", 0, 1, 0, 0, 0, 32'hAAAA_0010, 32'h5555_0020);
    chk("R5", "snapshot_value", 64'(rdata), 64'(MSK));
    cyc("R5", 0, 1, 0, 0, 0, 11, 12);              // cleared status reads zero
    chk("R5", "cleared", 64'(rdata), 64'(0));
    cyc("R3", 0, 0, 1, 4, 0, 13, 14);
    cyc("R3", 32'h0000_0100, 0, 0, 0, 0, 15, 16);
    chk("R3", "masked_irq_low", 64'(irq_o), 64'(0));
    cyc("R3", 0, 0, 1, 4, 32'h0000_0100, 17, 18);
    chk("R3", "enabled_irq_high", 64'(irq_o), 64'(1));
    cyc("R7", 32'h0000_0002, 1, 0, 0, 0, 32'h1234_5670, 32'h7654_3210);
    chk("R7", "snapshot_excludes_event", 64'(rdata), 64'(32'h100));
    cyc("R8", 0, 1, 0, 'h18, 0, 19, 20);
    chk("R8", "hold_reread", 64'(rdata), 64'(32'h100));
    cyc("R9", 0, 0, 1, 0, 32'hFFFF_FFFF, 21, 22);
    cyc("R9", 0, 0, 1, 'h18, 32'hFFFF_FFFF, 23, 24);
    cyc("R9", 0, 1, 0, 'h18, 0, 25, 26);
    cyc("R7", 0, 1, 0, 0, 0, 27, 28);
    chk("R7", "event_survived", 64'(rdata), 64'(32'h2));
    cyc("R10", 0, 1, 0, 'h010, 0, 29, 30);
    cyc("R10", 0, 0, 0, 0, 0, 31, 32);
    lf = 32'hACE1_2357;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cyc("R2", lf & {32{lf[3]}}, lf[5], lf[9],
          lf[7] ? ADDR_W'(0) : (lf[11] ? ADDR_W'(4) : (lf[12] ? ADDR_W'('h18) : ADDR_W'('h8))),
          ~lf, lf ^ 32'h0F0F_0F0F, ~lf ^ 32'h3333_3333);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule